// File: doc/BRIEF.md
# Two-Channel 4:2:2 to 4:4:4 Chroma Upsampler

This block accepts a 4:2:2 video stream spread over three 8-bit input ports. It captures the ports on the rising edge of the pixel clock and rebuilds two 12-bit words for each pixel. The luma word is the full Y value. The chroma word is multiplexed: the first pixel of each pair carries Cb, and the second carries the Cr that belongs to the same even pixel. The block separates the two chroma components and emits one complete 12-bit Y, Cb and Cr triple on every clock, so the output is a full-rate 4:4:4 stream.

A mode input decides how odd pixels get their chroma. In repeat mode they reuse the Cb/Cr pair of their even partner. In interpolate mode they take the rounded mean of the neighbouring pairs. Horizontal sync, vertical sync and data-enable travel through the same fixed pipeline as the video, so they stay aligned with it. They come either from the external sync pins or from a separately supplied set of sync signals, as a second mode input selects. Outside the active region, the video outputs are forced to blanking codes.

Top module: `chroma_upsampler`

## Requirements
- R1: For every active pixel, `y_out` equals {`port_b`, `port_a[3:0]`} of that pixel. It appears three clock edges after the edge that sampled it, so an input driven before edge k is visible after edge k+3.
- R2: The chroma word of a pixel is {`port_c`, `port_a[7:4]`}. An even (first-of-pair) active pixel outputs its own chroma word as `cb_out` and the chroma word of the following pixel as `cr_out`.
- R3: The pair phase restarts on each rising edge of the selected data-enable. The first active pixel of every line is treated as even, whatever the length of the previous line or gap.
- R4: In repeat mode (`interp_mode` = 0), an odd pixel outputs the same `cb_out` and `cr_out` as its even partner.
- R5: In interpolate mode (`interp_mode` = 1), an odd pixel whose next pair is active outputs Cb = (Cb_prev + Cb_next + 1) >> 1 and Cr = (Cr_prev + Cr_next + 1) >> 1. The sum is kept at 13 bits before the shift. The mode is sampled on the edge that loads the output register.
- R6: In interpolate mode, an odd pixel with no following active pair repeats its own pair's Cb and Cr.
- R7: While the output data-enable is low, `y_out` = 0x100 and `cb_out` = `cr_out` = 0x800.
- R8: With `embedded_mode` = 0, `hs_out`, `vs_out` and `de_out` equal `hs_in`, `vs_in` and `de_in` delayed by the same three edges as the video.
- R9: With `embedded_mode` = 1, `hs_in`, `vs_in` and `de_in` have no effect. `hs_out`, `vs_out` and `de_out` then follow `emb_hs`, `emb_vs` and `emb_de` with the same delay.
- R10: While `rst_n` is low at a clock edge, the outputs become `de_out` = `hs_out` = `vs_out` = 0, `y_out` = 0x100 and `cb_out` = `cr_out` = 0x800, and the pipeline holds no active pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| port_a | input | 8 | Low nibbles: luma [3:0] in bits 3:0, chroma [3:0] in bits 7:4 |
| port_b | input | 8 | Luma bits [11:4] |
| port_c | input | 8 | Chroma bits [11:4] |
| interp_mode | input | 1 | 0 = repeat chroma, 1 = interpolate chroma |
| embedded_mode | input | 1 | 0 = external sync pins, 1 = supplied sync signals |
| hs_in | input | 1 | External horizontal sync |
| vs_in | input | 1 | External vertical sync |
| de_in | input | 1 | External data enable |
| emb_hs | input | 1 | Supplied horizontal sync |
| emb_vs | input | 1 | Supplied vertical sync |
| emb_de | input | 1 | Supplied data enable |
| y_out | output | 12 | Luma output |
| cb_out | output | 12 | Blue-difference chroma output |
| cr_out | output | 12 | Red-difference chroma output |
| hs_out | output | 1 | Delayed horizontal sync |
| vs_out | output | 1 | Delayed vertical sync |
| de_out | output | 1 | Delayed data enable |

## Verification
Two behaviours can meet in the same cycle. One is the end-of-line fallback for an odd pixel in interpolate mode. The other is the phase restart when data-enable rises again after a gap of a single clock. The bench provokes this by following odd- and even-length lines with one-cycle gaps, by switching the mode between lines while earlier pixels are still in the pipeline, and by using saturated and alternating chroma patterns. Each output pixel is judged against a model that tracks pair phase and neighbour availability from the driven stream alone.

// File: rtl/upsamp_pkg.sv
package upsamp_pkg;

    typedef enum logic {
        CHR_REPEAT = 1'b0,
        CHR_INTERP = 1'b1
    } chroma_mode_e;

    typedef struct packed {
        logic hs;
        logic vs;
        logic de;
    } sync_t;

endpackage

// File: rtl/upsamp_window.sv
module upsamp_window #(
    parameter int PORT_W = 8,
    localparam int LOW_W = PORT_W / 2,
    localparam int CW    = PORT_W + LOW_W,
    localparam int TAPS  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [PORT_W-1:0]         port_a,
    input  logic [PORT_W-1:0]         port_b,
    input  logic [PORT_W-1:0]         port_c,
    input  upsamp_pkg::sync_t         sync_in,
    output logic [TAPS-1:0][CW-1:0]   c_tap,
    output logic [TAPS-1:0]           de_tap,
    output logic [CW-1:0]             y_mid,
    output logic                      odd_mid,
    output logic                      hs_mid,
    output logic                      vs_mid
);

    typedef struct packed {
        logic [CW-1:0] y;
        logic [CW-1:0] c;
        logic          de;
        logic          hs;
        logic          vs;
        logic          odd;
    } tap_t;

    tap_t [TAPS-1:0] win_d, win_q;

    // next state: newest sample enters tap 0, others shift toward tap 3
    always_comb begin
        win_d        = win_q;
        win_d[0].y   = {port_b, port_a[LOW_W-1:0]};
        win_d[0].c   = {port_c, port_a[PORT_W-1 -: LOW_W]};
        win_d[0].de  = sync_in.de;
        win_d[0].hs  = sync_in.hs;
        win_d[0].vs  = sync_in.vs;
        win_d[0].odd = sync_in.de & win_q[0].de & ~win_q[0].odd;
        for (int i = 1; i < TAPS; i++) begin
            win_d[i] = win_q[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) win_q <= '0;
        else        win_q <= win_d;
    end

    for (genvar g = 0; g < TAPS; g++) begin : g_tap
        assign c_tap[g]  = win_q[g].c;
        assign de_tap[g] = win_q[g].de;
    end

    assign y_mid   = win_q[2].y;
    assign odd_mid = win_q[2].odd;
    assign hs_mid  = win_q[2].hs;
    assign vs_mid  = win_q[2].vs;

    // R3
    line_start_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!win_q[1].de && win_q[0].de) |-> !win_q[0].odd);

    // R2
    phase_alternates_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (win_q[1].de && win_q[0].de) |-> (win_q[0].odd != win_q[1].odd));

endmodule

// File: rtl/upsamp_chroma.sv
module upsamp_chroma #(
    parameter int CW = 12,
    localparam int TAPS = 4,
    localparam logic [CW-1:0] BLANK_Y = CW'(1) << (CW - 4),
    localparam logic [CW-1:0] BLANK_C = CW'(1) << (CW - 1)
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  upsamp_pkg::chroma_mode_e  mode,
    input  logic [TAPS-1:0][CW-1:0]   c_tap,
    input  logic [TAPS-1:0]           de_tap,
    input  logic [CW-1:0]             y_mid,
    input  logic                      odd_mid,
    input  logic                      hs_mid,
    input  logic                      vs_mid,
    output logic [CW-1:0]             y_out,
    output logic [CW-1:0]             cb_out,
    output logic [CW-1:0]             cr_out,
    output logic                      hs_out,
    output logic                      vs_out,
    output logic                      de_out
);
    import upsamp_pkg::*;

    // tap roles around the pixel being emitted (tap 2)
    localparam int NEXT2 = 0;
    localparam int NEXT1 = 1;
    localparam int CUR   = 2;
    localparam int PREV  = 3;

    typedef struct packed {
        logic [CW-1:0] y;
        logic [CW-1:0] cb;
        logic [CW-1:0] cr;
        logic          hs;
        logic          vs;
        logic          de;
        logic          odd;
    } out_t;

    localparam out_t OUT_RST = '{y: BLANK_Y, cb: BLANK_C, cr: BLANK_C,
                                 hs: 1'b0, vs: 1'b0, de: 1'b0, odd: 1'b0};

    out_t out_d, out_q;

    function automatic logic [CW-1:0] avg2(input logic [CW-1:0] a, input logic [CW-1:0] b);
        logic [CW:0] s;
        s = {1'b0, a} + {1'b0, b} + (CW+1)'(1);
        return s[CW:1];
    endfunction

    logic next_pair_ok;
    assign next_pair_ok = de_tap[NEXT1] & de_tap[NEXT2];

    always_comb begin
        out_d     = OUT_RST;
        out_d.hs  = hs_mid;
        out_d.vs  = vs_mid;
        out_d.de  = de_tap[CUR];
        out_d.odd = odd_mid;
        if (de_tap[CUR]) begin
            out_d.y = y_mid;
            if (!odd_mid) begin
                out_d.cb = c_tap[CUR];
                out_d.cr = c_tap[NEXT1];
            end else if (mode == CHR_INTERP && next_pair_ok) begin
                out_d.cb = avg2(c_tap[PREV], c_tap[NEXT1]);
                out_d.cr = avg2(c_tap[CUR],  c_tap[NEXT2]);
            end else begin
                out_d.cb = c_tap[PREV];
                out_d.cr = c_tap[CUR];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= OUT_RST;
        else        out_q <= out_d;
    end

    assign y_out  = out_q.y;
    assign cb_out = out_q.cb;
    assign cr_out = out_q.cr;
    assign hs_out = out_q.hs;
    assign vs_out = out_q.vs;
    assign de_out = out_q.de;

    // R4
    repeat_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.de && out_q.odd && $past(mode) == CHR_REPEAT)
            |-> (out_q.cb == $past(out_q.cb) && out_q.cr == $past(out_q.cr)));

    // R3
    first_even_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_q.de) |-> !out_q.odd);

    // R5
    interp_bounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_q.de && out_q.odd && $past(mode) == CHR_INTERP && $past(next_pair_ok))
            |-> ((out_q.cb >= $past(c_tap[PREV]) || out_q.cb >= $past(c_tap[NEXT1])) &&
                 (out_q.cb <= $past(c_tap[PREV]) || out_q.cb <= $past(c_tap[NEXT1]))));

endmodule

// File: rtl/chroma_upsampler.sv
module chroma_upsampler #(
    parameter int PORT_W = 8,
    localparam int CW = PORT_W + PORT_W / 2,
    localparam int LAT = 3,
    localparam logic [CW-1:0] BLANK_Y = CW'(1) << (CW - 4),
    localparam logic [CW-1:0] BLANK_C = CW'(1) << (CW - 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PORT_W-1:0] port_a,
    input  logic [PORT_W-1:0] port_b,
    input  logic [PORT_W-1:0] port_c,
    input  logic              interp_mode,
    input  logic              embedded_mode,
    input  logic              hs_in,
    input  logic              vs_in,
    input  logic              de_in,
    input  logic              emb_hs,
    input  logic              emb_vs,
    input  logic              emb_de,
    output logic [CW-1:0]     y_out,
    output logic [CW-1:0]     cb_out,
    output logic [CW-1:0]     cr_out,
    output logic              hs_out,
    output logic              vs_out,
    output logic              de_out
);
    import upsamp_pkg::*;

    sync_t sync_sel;
    assign sync_sel = embedded_mode ? sync_t'{hs: emb_hs, vs: emb_vs, de: emb_de}
                                    : sync_t'{hs: hs_in,  vs: vs_in,  de: de_in};

    logic [3:0][CW-1:0] c_tap;
    logic [3:0]         de_tap;
    logic [CW-1:0]      y_mid;
    logic               odd_mid, hs_mid, vs_mid;

    upsamp_window #(.PORT_W(PORT_W)) u_window (
        .clk     (clk),
        .rst_n   (rst_n),
        .port_a  (port_a),
        .port_b  (port_b),
        .port_c  (port_c),
        .sync_in (sync_sel),
        .c_tap   (c_tap),
        .de_tap  (de_tap),
        .y_mid   (y_mid),
        .odd_mid (odd_mid),
        .hs_mid  (hs_mid),
        .vs_mid  (vs_mid)
    );

    upsamp_chroma #(.CW(CW)) u_chroma (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (chroma_mode_e'(interp_mode)),
        .c_tap   (c_tap),
        .de_tap  (de_tap),
        .y_mid   (y_mid),
        .odd_mid (odd_mid),
        .hs_mid  (hs_mid),
        .vs_mid  (vs_mid),
        .y_out   (y_out),
        .cb_out  (cb_out),
        .cr_out  (cr_out),
        .hs_out  (hs_out),
        .vs_out  (vs_out),
        .de_out  (de_out)
    );

    // checker warm-up: edges seen since reset released
    logic [2:0] since_rst_q;
    always_ff @(posedge clk) begin
        if (!rst_n)                 since_rst_q <= '0;
        else if (since_rst_q != '1) since_rst_q <= since_rst_q + 3'd1;
    end

    // R7
    blank_codes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !de_out |-> (y_out == BLANK_Y && cb_out == BLANK_C && cr_out == BLANK_C));

    // R8 R9
    sync_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 3'(LAT + 2)) |->
            (de_out == $past(sync_sel.de, LAT + 1) &&
             hs_out == $past(sync_sel.hs, LAT + 1) &&
             vs_out == $past(sync_sel.vs, LAT + 1)));

    // R1
    luma_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst_q >= 3'(LAT + 2) && de_out) |->
            (y_out == $past({port_b, port_a[PORT_W/2-1:0]}, LAT + 1)));

endmodule

// File: tb/chroma_upsampler_test.sv
module chroma_upsampler_test;

    localparam int PERIOD = 10;
    localparam int NMAX   = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  port_a = '0, port_b = '0, port_c = '0;
    logic        interp_mode = 1'b0, embedded_mode = 1'b0;
    logic        hs_in = 1'b0, vs_in = 1'b0, de_in = 1'b0;
    logic        emb_hs = 1'b0, emb_vs = 1'b0, emb_de = 1'b0;
    logic [11:0] y_out, cb_out, cr_out;
    logic        hs_out, vs_out, de_out;

    chroma_upsampler #(.PORT_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .port_a(port_a), .port_b(port_b), .port_c(port_c),
        .interp_mode(interp_mode), .embedded_mode(embedded_mode),
        .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
        .emb_hs(emb_hs), .emb_vs(emb_vs), .emb_de(emb_de),
        .y_out(y_out), .cb_out(cb_out), .cr_out(cr_out),
        .hs_out(hs_out), .vs_out(vs_out), .de_out(de_out)
    );

    always #(PERIOD/2) clk = ~clk;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc_n   = 0;
    logic mode_r = 1'b0;
    logic emb_r  = 1'b0;

    // driven stream, indexed by the edge that samples it
    logic [11:0] yv [NMAX];
    logic [11:0] cv [NMAX];
    logic        dv [NMAX];
    logic        hv [NMAX];
    logic        vv [NMAX];
    logic        ev [NMAX];
    logic        pv [NMAX];
    logic        mv [NMAX];

    function automatic logic gd(int p);  return (p < 0 || p >= NMAX) ? 1'b0 : dv[p]; endfunction
    function automatic logic gp(int p);  return (p < 0 || p >= NMAX) ? 1'b0 : pv[p]; endfunction
    function automatic logic gh(int p);  return (p < 0 || p >= NMAX) ? 1'b0 : hv[p]; endfunction
    function automatic logic gv(int p);  return (p < 0 || p >= NMAX) ? 1'b0 : vv[p]; endfunction
    function automatic logic ge(int p);  return (p < 0 || p >= NMAX) ? 1'b0 : ev[p]; endfunction
    function automatic logic gm(int p);  return (p < 0 || p >= NMAX) ? 1'b0 : mv[p]; endfunction
    function automatic int   gc(int p);  return (p < 0 || p >= NMAX) ? 0 : int'(cv[p]); endfunction
    function automatic int   gy(int p);  return (p < 0 || p >= NMAX) ? 0 : int'(yv[p]); endfunction

    task automatic chk(input string tag, input string what, input int got, input int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h (cycle %0d)", tag, what, got, exp, cyc_n);
        end
    endtask

    task automatic check_pixel(input int p);
        int ey, ecb, ecr;
        string ctag, ytag, stag;
        logic d;
        d    = gd(p);
        stag = ge(p) ? "R9" : "R8";
        if (!d) begin
            ey = 'h100; ecb = 'h800; ecr = 'h800;
            ctag = "R7"; ytag = "R7";
        end else begin
            ey = gy(p); ytag = "R1";
            if (!gp(p)) begin
                ecb  = gc(p);
                ecr  = gc(p + 1);
                ctag = gd(p - 1) ? "R2" : "R3";
            end else if (gm(p + 3) && gd(p + 1) && gd(p + 2)) begin
                ecb  = (gc(p - 1) + gc(p + 1) + 1) / 2;
                ecr  = (gc(p) + gc(p + 2) + 1) / 2;
                ctag = "R5";
            end else begin
                ecb  = gc(p - 1);
                ecr  = gc(p);
                ctag = gm(p + 3) ? "R6" : "R4";
            end
        end
        chk(stag, "de_out", int'(de_out), int'(d));
        chk(stag, "hs_out", int'(hs_out), int'(gh(p)));
        chk(stag, "vs_out", int'(vs_out), int'(gv(p)));
        chk(ytag, "y_out",  int'(y_out),  ey);
        chk(ctag, "cb_out", int'(cb_out), ecb);
        chk(ctag, "cr_out", int'(cr_out), ecr);
    endtask

    task automatic cycle(input logic [11:0] y, input logic [11:0] c, input logic d);
        logic h, v;
        @(negedge clk);
        if (cyc_n >= 1) check_pixel(cyc_n - 4);
        h = 1'($urandom);
        v = 1'($urandom);
        rst_n         = 1'b1;
        interp_mode   = mode_r;
        embedded_mode = emb_r;
        port_b = y[11:4];
        port_c = c[11:4];
        port_a = {c[3:0], y[3:0]};
        if (emb_r) begin
            emb_hs = h; emb_vs = v; emb_de = d;
            hs_in = 1'($urandom); vs_in = 1'($urandom); de_in = 1'($urandom);
        end else begin
            hs_in = h; vs_in = v; de_in = d;
            emb_hs = 1'($urandom); emb_vs = 1'($urandom); emb_de = 1'($urandom);
        end
        if (cyc_n < NMAX) begin
            yv[cyc_n] = y; cv[cyc_n] = c; dv[cyc_n] = d;
            hv[cyc_n] = h; vv[cyc_n] = v; ev[cyc_n] = emb_r; mv[cyc_n] = mode_r;
            pv[cyc_n] = d && gd(cyc_n - 1) && !gp(cyc_n - 1);
        end
        cyc_n++;
    endtask

    // pat 0: random chroma, 1: all full scale, 2: pairs alternating 0 / full scale
    task automatic run_line(input int len, input int gap, input int pat);
        logic [11:0] c;
        for (int i = 0; i < len; i++) begin
            if (pat == 1)      c = 12'hFFF;
            else if (pat == 2) c = ((i / 2) % 2 == 1) ? 12'hFFF : 12'h000;
            else               c = 12'($urandom);
            cycle(12'($urandom), c, 1'b1);
        end
        for (int g = 0; g < gap; g++) begin
            cycle(12'($urandom), 12'($urandom), 1'b0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: outputs while held in reset
        chk("R10", "de_out", int'(de_out), 0);
        chk("R10", "hs_out", int'(hs_out), 0);
        chk("R10", "vs_out", int'(vs_out), 0);
        chk("R10", "y_out",  int'(y_out),  'h100);
        chk("R10", "cb_out", int'(cb_out), 'h800);
        chk("R10", "cr_out", int'(cr_out), 'h800);

        for (int m = 0; m < 2; m++) begin
            for (int e = 0; e < 2; e++) begin
                mode_r = 1'(m);
                emb_r  = 1'(e);
                run_line(2, 3, 0);   // R6: lone pair in interpolate mode
                run_line(7, 1, 0);   // R3: odd length then one-cycle gap
                run_line(1, 3, 0);
                run_line(8, 1, 0);   // R5 interior, R6 at the tail
                run_line(4, 2, 1);   // R5 saturated sum
                run_line(6, 3, 2);   // R5 rounding at mid scale
                run_line(5, 1, 0);
            end
        end
        for (int k = 0; k < 8; k++) begin
            cycle(12'($urandom), 12'($urandom), 1'b0);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule